// File: doc/BRIEF.md
# Mode-Qualified Event Counter Bank

This block holds up to four 32-bit event counters. Each counter has its own 15-bit control word. Every clock cycle, a counter adds one when two things are true:

- the event chosen by its control word fires in that cycle, and
- the current processor privilege state is one its control word allows.

Event pulses arrive as vectors, one bit per event, each cycle. Even-numbered and odd-numbered counters draw on different pulse vectors, so a single event code can mean one thing on an even counter and another on an odd counter.

Software reaches counters and control words through a small register port. The port uses a kind bit and a 3-bit slot index, and a read returns its data one cycle later. Bit 31 of each counter serves as its overflow flag. When a counter has bit 31 set and its control word allows interrupts, the shared interrupt line asserts. A status bit copies that line, so a shared handler can tell this source apart from others.

Each control word carries a read-only chain bit. Software walks these bits to find out how many counters exist, and a fixed configuration word reports that counters are present at all. To pause all counting, software saves each control word and writes it back with its mode and interrupt bits cleared. Writing the saved values back later resumes counting.

Top module: `evt_ctr_bank`

## Requirements
- R1: Control word bits: [0] exception-level enable, [1] kernel enable, [2] supervisor enable, [3] user enable, [4] interrupt enable, [14:5] event code. Bits 30:15 ignore writes and read 0.
- R2: Control bit 31 is read-only. It reads 1 on every implemented counter except the highest one, where it reads 0.
- R3: When `exl_i` or `erl_i` is 1, a counter may count only if control bit 0 is set. When both are 0, `ksu_i` selects the enable bit: 00 selects kernel (bit 1), 01 supervisor (bit 2), 10 user (bit 3), and 11 never counts.
- R4: Event codes select events as follows:
  - Code 0 counts every cycle.
  - Code 1 counts cycles with `instr_done_i` high.
  - Code 2+k counts `evt_even_i[k]` on even counters and `evt_odd_i[k]` on odd counters.
  - All other codes never count.
  - Each counter adds at most one per cycle.
- R5: A register-port write to a counter wins over an increment in the same cycle. The written value is stored.
- R6: `irq_o` is 1 exactly when some counter has bit 31 set and its interrupt enable set. It stays 1 until software writes that counter with bit 31 clear.
- R7: `irq_pend_o` always equals `irq_o`.
- R8: With control bits 4:0 all zero, a counter holds its value. Writing the earlier control word back resumes counting and restores its interrupt.
- R9: After reset, or after zero is written to every control and counter register, all counters read 0 and `irq_o` is 0.
- R10: The register port behaves as follows:
  - `reg_ctl_i` picks control (1) or counter (0).
  - `reg_idx_i` picks the slot.
  - Read data appears on `reg_rdata_o` one cycle after `reg_re_i`.
  - A slot at or above the counter count reads 0, and writes to it change nothing.
- R11: `cfg_o` reads 0x00000010: bit 4 says counters are present, and all other bits are 0.
- R12: A counter wraps from 0xFFFFFFFF to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ksu_i | input | 2 | Privilege field: 00 kernel, 01 supervisor, 10 user |
| exl_i | input | 1 | Exception-level flag |
| erl_i | input | 1 | Error-level flag |
| instr_done_i | input | 1 | Instruction-completed pulse (code 1) |
| evt_even_i | input | NUM_XEVT | Pulses for codes 2.. on even counters |
| evt_odd_i | input | NUM_XEVT | Pulses for codes 2.. on odd counters |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_ctl_i | input | 1 | 1 selects control word, 0 selects counter |
| reg_idx_i | input | 3 | Slot index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_o | output | 1 | Overflow interrupt |
| irq_pend_o | output | 1 | Pending-interrupt status bit |
| cfg_o | output | 32 | Configuration word |

## Verification
The bench targets the following corner cases, each with the fault it would expose:

- **Exception flag over user mode.** The bench raises the exception flag while user mode is selected. A gate that looked only at the privilege field would keep counting.
- **Code 2 on even and odd counters.** The bench drives code 2 on both kinds of counter with different pulse patterns. A shared decode would give the same count on both.
- **Write in the same cycle as an increment.** The bench writes a counter in the very cycle it increments. A design that let the increment win would read back one higher.
- **Pause and resume.** The bench checks that a paused counter holds its value while its interrupt drops, and that the interrupt comes back on resume.
- **Wrap and out-of-range slots.** The bench checks the wrap from all ones to zero. It also checks that out-of-range slots read 0 and do not alias onto real counters.

// File: rtl/evt_ctr_pkg.sv
// Shared constants and the privilege-mode gate for the event counter bank.
// Assumes a 2-bit privilege field with 00 = kernel, 01 = supervisor, 10 = user.
package evt_ctr_pkg;
    localparam int CNT_W     = 32;
    localparam int CTL_W     = 15;
    localparam int IDX_W     = 3;
    localparam int CODE_W    = 10;
    localparam int B_EXL     = 0;
    localparam int B_KER     = 1;
    localparam int B_SUP     = 2;
    localparam int B_USR     = 3;
    localparam int B_IE      = 4;
    localparam int CODE_LSB  = 5;
    localparam int CODE_BASE = 2;
    localparam logic [31:0] CFG_WORD = 32'h0000_0010;

    typedef enum logic [1:0] {
        PRIV_KERNEL = 2'b00,
        PRIV_SUPER  = 2'b01,
        PRIV_USER   = 2'b10,
        PRIV_RSVD   = 2'b11
    } priv_e;

    // Decide whether the current privilege state lets a counter run.
    function automatic logic mode_allows(input logic [CTL_W-1:0] ctl,
                                         input priv_e priv,
                                         input logic exl, input logic erl);
        logic ok;
        if (exl || erl) begin
            ok = ctl[B_EXL];
        end else begin
            case (priv)
                PRIV_KERNEL: ok = ctl[B_KER];
                PRIV_SUPER:  ok = ctl[B_SUP];
                PRIV_USER:   ok = ctl[B_USR];
                default:     ok = 1'b0;
            endcase
        end
        return ok;
    endfunction
endpackage

// File: rtl/evt_ctr_slice.sv
// One counter and its control word.
// Decodes the event code against the pulse set handed in by the parent
// (even or odd set) and gates the increment with the privilege mode.
// Assumes the parent resolves the slot index into the two write strobes.
module evt_ctr_slice
    import evt_ctr_pkg::*;
#(
    parameter int NUM_XEVT = 4,
    parameter bit IS_LAST  = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          ksu_i,
    input  logic                exl_i,
    input  logic                erl_i,
    input  logic                instr_i,
    input  logic [NUM_XEVT-1:0] xevt_i,
    input  logic                cnt_we_i,
    input  logic                ctl_we_i,
    input  logic [CNT_W-1:0]    wdata_i,
    output logic [CNT_W-1:0]    cnt_o,
    output logic [31:0]         ctl_o,
    output logic                irq_term_o
);
    logic [CTL_W-1:0]  ctl_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-1:0] code;
    logic              evt_hit;
    logic              mode_ok;

    assign code    = ctl_q[CODE_LSB +: CODE_W];
    assign mode_ok = mode_allows(ctl_q, priv_e'(ksu_i), exl_i, erl_i);

    // Pick the pulse the event code names on this counter.
    always_comb begin
        evt_hit = 1'b0;
        if (code == CODE_W'(0)) begin
            evt_hit = 1'b1;
        end else if (code == CODE_W'(1)) begin
            evt_hit = instr_i;
        end else begin
            for (int k = 0; k < NUM_XEVT; k++) begin
                if (code == CODE_W'(CODE_BASE + k)) evt_hit = xevt_i[k];
            end
        end
    end

    // Count register: a port write wins over an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (cnt_we_i)           cnt_q <= wdata_i;
        else if (evt_hit && mode_ok) cnt_q <= cnt_q + 1'b1;
    end

    // Control register: only the low writable field is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctl_q <= '0;
        else if (ctl_we_i) ctl_q <= wdata_i[CTL_W-1:0];
    end

    assign cnt_o      = cnt_q;
    assign ctl_o      = {~IS_LAST, {(31-CTL_W){1'b0}}, ctl_q};
    assign irq_term_o = cnt_q[CNT_W-1] & ctl_q[B_IE];
endmodule

// File: rtl/evt_ctr_rdport.sv
// Registered read multiplexer over all index slots.
// Assumes unused slots arrive already tied to zero.
module evt_ctr_rdport
    import evt_ctr_pkg::*;
#(
    parameter int NUM_SLOT = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      re_i,
    input  logic                      ctl_i,
    input  logic [IDX_W-1:0]          idx_i,
    input  logic [NUM_SLOT*CNT_W-1:0] cnt_flat_i,
    input  logic [NUM_SLOT*32-1:0]    ctl_flat_i,
    output logic [31:0]               rdata_o
);
    // Capture the selected word one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (re_i) begin
            if (ctl_i) rdata_o <= ctl_flat_i[idx_i*32 +: 32];
            else       rdata_o <= cnt_flat_i[idx_i*CNT_W +: CNT_W];
        end
    end
endmodule

// File: rtl/evt_ctr_bank.sv
// Bank of NUM_CTR mode-qualified event counters behind a register port.
// Even slots take evt_even_i, odd slots take evt_odd_i. Slots past NUM_CTR
// read zero and have no storage. NUM_CTR must be 1..4.
module evt_ctr_bank
    import evt_ctr_pkg::*;
#(
    parameter int NUM_CTR  = 4,
    parameter int NUM_XEVT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          ksu_i,
    input  logic                exl_i,
    input  logic                erl_i,
    input  logic                instr_done_i,
    input  logic [NUM_XEVT-1:0] evt_even_i,
    input  logic [NUM_XEVT-1:0] evt_odd_i,
    input  logic                reg_we_i,
    input  logic                reg_re_i,
    input  logic                reg_ctl_i,
    input  logic [2:0]          reg_idx_i,
    input  logic [31:0]         reg_wdata_i,
    output logic [31:0]         reg_rdata_o,
    output logic                irq_o,
    output logic                irq_pend_o,
    output logic [31:0]         cfg_o
);
    localparam int NUM_SLOT = 1 << IDX_W;

    logic [NUM_SLOT*CNT_W-1:0] cnt_flat;
    logic [NUM_SLOT*32-1:0]    ctl_flat;
    logic [NUM_SLOT-1:0]       irq_term;

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
        if (g < NUM_CTR) begin : g_ctr
            evt_ctr_slice #(
                .NUM_XEVT (NUM_XEVT),
                .IS_LAST  (g == NUM_CTR - 1)
            ) u_slice (
                .clk        (clk),
                .rst_n      (rst_n),
                .ksu_i      (ksu_i),
                .exl_i      (exl_i),
                .erl_i      (erl_i),
                .instr_i    (instr_done_i),
                .xevt_i     (((g % 2) == 1) ? evt_odd_i : evt_even_i),
                .cnt_we_i   (reg_we_i && !reg_ctl_i && (reg_idx_i == IDX_W'(g))),
                .ctl_we_i   (reg_we_i &&  reg_ctl_i && (reg_idx_i == IDX_W'(g))),
                .wdata_i    (reg_wdata_i),
                .cnt_o      (cnt_flat[g*CNT_W +: CNT_W]),
                .ctl_o      (ctl_flat[g*32 +: 32]),
                .irq_term_o (irq_term[g])
            );
        end else begin : g_pad
            assign cnt_flat[g*CNT_W +: CNT_W] = '0;
            assign ctl_flat[g*32 +: 32]       = '0;
            assign irq_term[g]                = 1'b0;
        end
    end

    evt_ctr_rdport #(.NUM_SLOT(NUM_SLOT)) u_rdport (
        .clk        (clk),
        .rst_n      (rst_n),
        .re_i       (reg_re_i),
        .ctl_i      (reg_ctl_i),
        .idx_i      (reg_idx_i),
        .cnt_flat_i (cnt_flat),
        .ctl_flat_i (ctl_flat),
        .rdata_o    (reg_rdata_o)
    );

    assign irq_o      = |irq_term;
    assign irq_pend_o = irq_o;
    assign cfg_o      = CFG_WORD;
endmodule

// File: rtl/evt_ctr_bank_chk.sv
// Assertion checker for evt_ctr_bank, watching slot 0 and the read port.
// Attached by the bind at the end of this file.
module evt_ctr_bank_chk #(
    parameter int NUM_CTR = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we_i,
    input logic        reg_re_i,
    input logic        reg_ctl_i,
    input logic [2:0]  reg_idx_i,
    input logic [31:0] reg_wdata_i,
    input logic [31:0] reg_rdata_o,
    input logic [31:0] cnt0_i,
    input logic [31:0] ctl0_i
);
    logic wr_cnt0;
    logic wr_ctl0;
    assign wr_cnt0 = reg_we_i && !reg_ctl_i && (reg_idx_i == 3'd0);
    assign wr_ctl0 = reg_we_i &&  reg_ctl_i && (reg_idx_i == 3'd0);

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt0 |=> cnt0_i == $past(reg_wdata_i)); // R5
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0_i[4:0] == 5'd0 && !wr_cnt0) |=> $stable(cnt0_i)); // R8
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cnt0 |=> (cnt0_i == $past(cnt0_i)) || (cnt0_i == $past(cnt0_i) + 32'd1)); // R4
    AST_CHAIN_RO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl0 |=> ctl0_i[31] == $past(ctl0_i[31])); // R2
    AST_OOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re_i && (int'(reg_idx_i) >= NUM_CTR)) |=> reg_rdata_o == 32'd0); // R10
endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(.NUM_CTR(NUM_CTR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we_i    (reg_we_i),
    .reg_re_i    (reg_re_i),
    .reg_ctl_i   (reg_ctl_i),
    .reg_idx_i   (reg_idx_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .cnt0_i      (cnt_flat[31:0]),
    .ctl0_i      (ctl_flat[31:0])
);

// File: tb/evt_ctr_bank_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a table of mode/event vectors, then directed tests.
module evt_ctr_bank_tb_top;
    localparam int NX  = 4;
    localparam int WIN = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ksu = 2'b00;
    logic          exl = 1'b0, erl = 1'b0, instr = 1'b0;
    logic [NX-1:0] ev_even = '0, ev_odd = '0;
    logic          we = 1'b0, re = 1'b0, selc = 1'b0;
    logic [2:0]    idx = 3'd0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata, cfg;
    logic          irq, irq_pend;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    evt_ctr_bank #(.NUM_CTR(4), .NUM_XEVT(NX)) dut_i (
        .clk(clk), .rst_n(rst_n), .ksu_i(ksu), .exl_i(exl), .erl_i(erl),
        .instr_done_i(instr), .evt_even_i(ev_even), .evt_odd_i(ev_odd),
        .reg_we_i(we), .reg_re_i(re), .reg_ctl_i(selc), .reg_idx_i(idx),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
        .irq_pend_o(irq_pend), .cfg_o(cfg)
    );

    // Vector: {slot[28:27], ksu[26:25], exl[24], erl[23], ctl[22:18], code[17:8], expected[7:0]}
    localparam logic [28:0] VEC [12] = '{
        {2'd0, 2'b00, 1'b0, 1'b0, 5'h02, 10'd0, 8'd6},  // R3 kernel cycles
        {2'd0, 2'b10, 1'b0, 1'b0, 5'h02, 10'd0, 8'd0},  // R3 user blocked
        {2'd0, 2'b10, 1'b0, 1'b0, 5'h08, 10'd1, 8'd2},  // R4 instructions
        {2'd0, 2'b01, 1'b0, 1'b0, 5'h04, 10'd2, 8'd6},  // R4 even code 2
        {2'd1, 2'b01, 1'b0, 1'b0, 5'h04, 10'd2, 8'd3},  // R4 odd code 2
        {2'd0, 2'b10, 1'b1, 1'b0, 5'h08, 10'd0, 8'd0},  // R3 exl overrides user
        {2'd0, 2'b10, 1'b1, 1'b0, 5'h01, 10'd0, 8'd6},  // R3 exl enable
        {2'd1, 2'b00, 1'b0, 1'b1, 5'h01, 10'd1, 8'd2},  // R3 erl enable
        {2'd1, 2'b11, 1'b0, 1'b0, 5'h0E, 10'd0, 8'd0},  // R3 reserved field
        {2'd0, 2'b00, 1'b0, 1'b0, 5'h02, 10'd7, 8'd0},  // R4 unknown code
        {2'd2, 2'b00, 1'b0, 1'b0, 5'h02, 10'd5, 8'd6},  // R4 even code 5
        {2'd3, 2'b00, 1'b0, 1'b0, 5'h02, 10'd5, 8'd3}   // R4 odd code 5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input bit c, input int i, input logic [31:0] d);
        we = 1'b1; selc = c; idx = 3'(i); wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic reg_rd(input bit c, input int i, output logic [31:0] d);
        re = 1'b1; selc = c; idx = 3'(i);
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v, a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R9, R2, R11)
        reg_rd(1'b0, 0, v); check("R9 counter0 after reset", v, 32'h0);
        reg_rd(1'b1, 0, v); check("R2 chain on slot0", v, 32'h8000_0000);
        reg_rd(1'b1, 3, v); check("R2 chain clear on last", v, 32'h0);
        check("R9 irq after reset", {31'd0, irq}, 32'h0);
        check("R11 config word", cfg, 32'h0000_0010);

        // Table walk: mode gating and event decode (R3, R4)
        for (int n = 0; n < 12; n++) begin
            int s;
            s = int'(VEC[n][28:27]);
            reg_wr(1'b1, s, {17'd0, VEC[n][17:8], VEC[n][22:18]});
            reg_wr(1'b0, s, 32'h0);
            for (int i = 1; i <= WIN; i++) begin
                ksu = VEC[n][26:25]; exl = VEC[n][24]; erl = VEC[n][23];
                instr = (i % 3 == 0);
                ev_even = '1;
                ev_odd = (i % 2 == 0) ? '1 : '0;
                if (i == WIN) begin we = 1'b1; selc = 1'b1; idx = 3'(s); wdata = 32'h0; end
                @(negedge clk);
            end
            we = 1'b0; ksu = 2'b00; exl = 1'b0; erl = 1'b0;
            instr = 1'b0; ev_even = '0; ev_odd = '0;
            reg_rd(1'b0, s, v);
            check($sformatf("R3/R4 vector %0d", n), v, {24'd0, VEC[n][7:0]});
        end

        // Control layout and read-only chain (R1, R2)
        reg_wr(1'b1, 1, 32'hFFFF_FFF0);
        reg_rd(1'b1, 1, v); check("R1 writable field only", v, 32'h8000_7FF0);
        reg_wr(1'b1, 1, 32'h0);
        reg_wr(1'b1, 3, 32'h8000_0000);
        reg_rd(1'b1, 3, v); check("R2 chain not writable", v, 32'h0);

        // Write beats increment (R5)
        reg_wr(1'b1, 0, 32'h0000_0002);
        reg_wr(1'b0, 0, 32'h0000_1234);
        reg_rd(1'b0, 0, v); check("R5 write over increment", v, 32'h0000_1234);
        reg_wr(1'b1, 0, 32'h0);

        // Overflow interrupt, freeze and resume (R6, R7, R8)
        reg_wr(1'b1, 0, 32'h0000_0012);
        reg_wr(1'b0, 0, 32'h7FFF_FFFE);
        check("R6 no irq below bit 31", {31'd0, irq}, 32'h0);
        @(negedge clk);
        @(negedge clk);
        check("R6 irq on bit 31", {31'd0, irq}, 32'h1);
        check("R7 pending mirrors irq", {31'd0, irq_pend}, 32'h1);
        reg_wr(1'b1, 0, 32'h0);
        check("R8 irq drops while paused", {31'd0, irq}, 32'h0);
        reg_rd(1'b0, 0, a);
        repeat (3) @(negedge clk);
        reg_rd(1'b0, 0, b);
        check("R8 paused counter holds", b, a);
        reg_wr(1'b1, 0, 32'h0000_0012);
        check("R8 irq back on resume", {31'd0, irq}, 32'h1);
        @(negedge clk);
        reg_rd(1'b0, 0, v); check("R8 counting resumes", v, b + 32'd1);
        reg_wr(1'b0, 0, 32'h0);
        check("R6 irq cleared by write", {31'd0, irq}, 32'h0);
        check("R7 pending cleared", {31'd0, irq_pend}, 32'h0);
        reg_wr(1'b1, 0, 32'h0);

        // Wrap (R12)
        reg_wr(1'b1, 0, 32'h0000_0002);
        reg_wr(1'b0, 0, 32'hFFFF_FFFF);
        reg_wr(1'b1, 0, 32'h0);
        reg_rd(1'b0, 0, v); check("R12 wrap to zero", v, 32'h0);

        // Out-of-range slots (R10)
        reg_rd(1'b0, 1, a);
        reg_wr(1'b0, 5, 32'h0000_ABCD);
        reg_wr(1'b1, 5, 32'h0000_0012);
        reg_rd(1'b0, 5, v); check("R10 slot 5 counter reads 0", v, 32'h0);
        reg_rd(1'b1, 6, v); check("R10 slot 6 control reads 0", v, 32'h0);
        reg_rd(1'b0, 1, b); check("R10 no alias onto slot 1", b, a);
        reg_rd(1'b1, 1, v); check("R10 slot 1 control untouched", v, 32'h8000_0000);

        // Zero everything (R9)
        for (int s = 0; s < 4; s++) begin
            reg_wr(1'b1, s, 32'h0);
            reg_wr(1'b0, s, 32'h0);
        end
        repeat (3) @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            reg_rd(1'b0, s, v);
            check($sformatf("R9 counter %0d zero", s), v, 32'h0);
        end
        check("R9 irq quiet", {31'd0, irq}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule